// File: doc/BRIEF.md
# Processor/Memory Read-Write Buffer

This block sits between a processor-side port A and a memory-side port B and carries data both ways. Writes move from A to B through a four-entry synchronous queue. One clock drives the queue, and two active-low enables decide whether a word goes in or comes out on each rising edge. The queue's output word is registered. When the queue holds four words, an active-low full flag tells the producer to stop. An active-low synchronous reset empties the queue and sets the output word to all ones.

Reads move from B to A through a level-sensitive latch that runs independently of the clock. While the latch enable is high, port A follows port B. When the latch enable falls, the latch captures the value on port B and holds it until the enable rises again. Each port has an active-low output enable. It is modelled as a data bus plus an active-high drive flag rather than as a tri-state pad.

The write path is controlled by plain enables rather than a valid/ready handshake. The full flag is the only back-pressure signal. A write offered while the flag is low is dropped rather than stalled, so the producer must hold the word and offer it again.

Top module: `rw_buffer`

## Requirements
- R1: On a rising clock edge with `wr_en_n` low and fewer than four words stored, `a_in` is stored. Words leave in the order they were stored.
- R2: On a rising clock edge with `rd_en_n` low and at least one word stored, the oldest word is removed and appears on `b_out` after that same edge. `b_out` does not change at any other time except reset.
- R3: A write requested while four words are stored is ignored. The stored contents and `full_n` are unchanged.
- R4: A read requested while the queue is empty has no effect, and `b_out` keeps its previous value.
- R5: When both enables are low on one edge, both operations are performed. The exception is at the boundaries: when empty, only the write is performed; when full, only the read is performed.
- R6: `full_n` is low exactly when four words are stored, and it is high after reset.
- R7: With `rst_n` low on a rising edge, the queue becomes empty and `b_out` becomes all ones. Reset wins over both enables on that edge.
- R8: While `latch_en` is high, `a_out` equals `b_in`. On the falling edge of `latch_en`, the current `b_in` is captured and `a_out` holds that value while `latch_en` stays low, regardless of the clock or queue activity.
- R9: `b_drv` is high exactly when `b_oe_n` is low, and `a_drv` is high exactly when `a_oe_n` is low. The output enables do not affect the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Queue clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| a_in | input | 18 | Data arriving on port A |
| full_n | output | 1 | Queue full flag, active low |
| b_out | output | 18 | Queue output word toward port B |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_drv | output | 1 | Port B is being driven |
| b_in | input | 18 | Data arriving on port B |
| latch_en | input | 1 | Read-path latch enable, transparent when high |
| a_out | output | 18 | Latch output toward port A |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_drv | output | 1 | Port A is being driven |

## Verification
Directed sequences fill the queue to full and then drain it past empty. They show that an extra write at four words and an extra read at zero words are both dropped, and that the output word is held in the read-at-zero case. Simultaneous read and write are applied at zero, two and four entries, which separates the both-execute case from the two boundary cases. Reset is applied mid-stream with the enables low to confirm it takes priority. A long stretch of seeded random enables and data is then compared cycle by cycle against a queue model, to catch ordering and pointer-wrap errors. The latch is exercised by toggling its enable while port B data and queue activity change, which separates transparent behaviour from capture and hold.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  // Queue operation decided for one clock edge
  typedef struct packed {
    logic push;
    logic pop;
  } rwb_op_t;
endpackage

// File: rtl/rwb_arb.sv
module rwb_arb #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0]   occ,
  input  logic            wr_req,
  input  logic            rd_req,
  output rwb_pkg::rwb_op_t op
);
  logic is_full, is_empty;

  assign is_full  = (occ == CW'(DEPTH));
  assign is_empty = (occ == '0);

  // Only the legal operation survives at a boundary
  always_comb begin
    op.push = wr_req && !is_full;
    op.pop  = rd_req && !is_empty;
  end
endmodule

// File: rtl/rwb_fifo.sv
module rwb_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rwb_pkg::rwb_op_t op,
  input  logic [W-1:0]     din,
  output logic [CW-1:0]    occ,
  output logic [W-1:0]     dout
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (op.push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      occ  <= '0;
      dout <= '1;
    end else begin
      if (op.push) wp <= bump(wp);
      if (op.pop) begin
        rp   <= bump(rp);
        dout <= store[rp];
      end
      case ({op.push, op.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/rwb_rdlatch.sv
module rwb_rdlatch #(
  parameter int W = 18
) (
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_latch begin
    if (le) held <= d;
  end

  assign q = le ? d : held;
endmodule

// File: rtl/rwb_port.sv
module rwb_port #(
  parameter int W = 18
) (
  input  logic [W-1:0] d,
  input  logic         oe_n,
  output logic [W-1:0] q,
  output logic         drv
);
  assign q   = d;
  assign drv = !oe_n;
endmodule

// File: rtl/rw_buffer.sv
module rw_buffer #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_n,
  input  logic         rd_en_n,
  input  logic [W-1:0] a_in,
  output logic         full_n,
  output logic [W-1:0] b_out,
  input  logic         b_oe_n,
  output logic         b_drv,
  input  logic [W-1:0] b_in,
  input  logic         latch_en,
  output logic [W-1:0] a_out,
  input  logic         a_oe_n,
  output logic         a_drv
);
  rwb_pkg::rwb_op_t op;
  logic [CW-1:0]    occ;
  logic [W-1:0]     q_word, l_word;

  rwb_arb #(.DEPTH(DEPTH)) u_arb (
    .occ(occ), .wr_req(!wr_en_n), .rd_req(!rd_en_n), .op(op)
  );

  rwb_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .op(op), .din(a_in), .occ(occ), .dout(q_word)
  );

  rwb_rdlatch #(.W(W)) u_latch (.le(latch_en), .d(b_in), .q(l_word));

  rwb_port #(.W(W)) u_bport (.d(q_word), .oe_n(b_oe_n), .q(b_out), .drv(b_drv));
  rwb_port #(.W(W)) u_aport (.d(l_word), .oe_n(a_oe_n), .q(a_out), .drv(a_drv));

  assign full_n = (occ != CW'(DEPTH));
endmodule

// File: rtl/rwb_chk.sv
module rwb_chk #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en_n,
  input logic         rd_en_n,
  input logic         full_n,
  input logic [W-1:0] b_out,
  input logic         latch_en,
  input logic [W-1:0] a_out
);
  // Occupancy seen from the ports only
  logic [CW-1:0] seen;
  logic          wok, rok;

  assign wok = !wr_en_n && (seen != CW'(DEPTH));
  assign rok = !rd_en_n && (seen != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (wok && !rok) seen <= seen + 1'b1;
    else if (rok && !wok) seen <= seen - 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (full_n && b_out == '1)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_en_n && rd_en_n) |=> !full_n && $stable(b_out)); // R3

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == '0 && !rd_en_n) |=> $stable(b_out)); // R4

  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    full_n == (seen != CW'(DEPTH))); // R6

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_en && $past(!latch_en)) |-> $stable(a_out)); // R8
endmodule

bind rw_buffer rwb_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
  .full_n(full_n), .b_out(b_out), .latch_en(latch_en), .a_out(a_out)
);

// File: tb/test_rw_buffer.sv
`timescale 1ns/1ps
module test_rw_buffer;
  localparam int W = 18;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic b_oe_n = 1'b1, a_oe_n = 1'b1, latch_en = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic full_n, b_drv, a_drv;
  logic [W-1:0] b_out, a_out;

  int total = 0, bad = 0;
  logic [W-1:0] mq[$];
  logic [W-1:0] exp_b;
  string tag;

  always #2.5 clk = ~clk;

  rw_buffer #(.W(W), .DEPTH(DEPTH)) i_rw_buffer (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .a_in(a_in), .full_n(full_n), .b_out(b_out), .b_oe_n(b_oe_n),
    .b_drv(b_drv), .b_in(b_in), .latch_en(latch_en), .a_out(a_out),
    .a_oe_n(a_oe_n), .a_drv(a_drv)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_full_n();
    return mq.size() != DEPTH;
  endfunction

  // Drive at negedge, let one posedge pass, check at next negedge
  task automatic step(input logic wr, input logic rd, input logic [W-1:0] d);
    logic dw, dr;
    wr_en_n = !wr; rd_en_n = !rd; a_in = d;
    dw = wr && mq.size() < DEPTH;
    dr = rd && mq.size() > 0;
    @(posedge clk);
    if (dr) exp_b = mq.pop_front();
    if (dw) mq.push_back(d);
    @(negedge clk);
    chk({tag, " R2 data"}, b_out, exp_b);
    chk({tag, " R6 full"}, W'(full_n), W'(exp_full_n()));
    wr_en_n = 1'b1; rd_en_n = 1'b1;
  endtask

  task automatic do_reset(input logic wr, input logic rd);
    wr_en_n = !wr; rd_en_n = !rd; rst_n = 1'b0; a_in = 18'h2AAAA;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
    mq.delete(); exp_b = '1;
    chk("R7 reset out", b_out, '1);
    chk("R7 reset full", W'(full_n), W'(1'b1));
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset(1'b0, 1'b0);

    tag = "R4"; step(1'b0, 1'b1, 18'h00001);           // read on empty holds ones
    tag = "R1"; for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, W'(18'h100 + i));
    chk("R6 low at four", W'(full_n), W'(1'b0));
    tag = "R3"; step(1'b1, 1'b0, 18'h3FFFE);           // dropped write
    tag = "R5"; step(1'b1, 1'b1, 18'h0ABCD);           // full: read only
    chk("R5 full both pops oldest", b_out, 18'h00100);
    tag = "R1"; for (int i = 0; i < 5; i++) step(1'b0, 1'b1, '0); // drain past empty
    chk("R4 hold after drain", b_out, 18'h00103);
    tag = "R5"; step(1'b1, 1'b1, 18'h05555);           // empty: write only
    chk("R5 empty both keeps out", b_out, 18'h00103);
    step(1'b1, 1'b0, 18'h06666);                        // now two entries
    step(1'b1, 1'b1, 18'h07777);                        // both execute
    chk("R5 mid both pops", b_out, 18'h05555);
    chk("R5 mid both count", W'(full_n), W'(1'b1));

    // reset mid-stream with enables asserted
    step(1'b1, 1'b0, 18'h08888);
    do_reset(1'b1, 1'b1);
    tag = "R7"; step(1'b0, 1'b1, '0);
    chk("R7 empty after reset", b_out, '1);

    // seeded random traffic
    tag = "R1 rand";
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, ($urandom % 3) == 0 || i > 300, W'($urandom));

    // read-path latch while the queue runs
    b_oe_n = 1'b0; a_oe_n = 1'b1; #1;
    chk("R9 b drive", W'(b_drv), W'(1'b1));
    chk("R9 a idle", W'(a_drv), W'(1'b0));
    a_oe_n = 1'b0; b_oe_n = 1'b1; #1;
    chk("R9 a drive", W'(a_drv), W'(1'b1));
    chk("R9 b idle", W'(b_drv), W'(1'b0));
    latch_en = 1'b1; b_in = 18'h1234A; #1;
    chk("R8 transparent", a_out, 18'h1234A);
    b_in = 18'h2F00F; #1;
    chk("R8 follows", a_out, 18'h2F00F);
    latch_en = 1'b0; #1; b_in = 18'h00777; #1;
    chk("R8 captured", a_out, 18'h2F00F);
    tag = "R9 indep";
    step(1'b1, 1'b0, 18'h13579); step(1'b0, 1'b1, '0);
    chk("R8 hold across clock", a_out, 18'h2F00F);
    latch_en = 1'b1; #1;
    chk("R8 reopen", a_out, 18'h00777);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule